// File: doc/BRIEF.md
# Randomized Inversion Codec for Weight Memory

This block sits on both sides of an on-chip weight SRAM and keeps every storage cell near an even split of time spent holding one and holding zero. A decision unit picks one flip bit for each incoming block of weights. The write stage then passes every word of that block either unchanged or fully inverted. Each bit of the stage is a single XOR gate driven by the shared flip bit.

The flip bit is stored per block slot in a small flag file. When a word is read back from a slot, a read stage with the same XOR structure looks up that slot's flag and restores the original word before it reaches compute. The flip bit comes from a random source: either a one-bit input port or an internal 16-bit maximal-length LFSR, selected by a parameter.

A real generator may lean towards one value. To cancel that lean, an M-bit block counter toggles an inversion phase each time it wraps. The flip bit is the random bit XOR this phase, so a biased source is inverted for half of each run of 2^(M+1) blocks.

Top module: `wflip_codec`

## Requirements
- R1: After reset both output valids are low, the write output word is zero, the phase is zero, and every slot flag is zero, so a read of any slot returns its input word unchanged.
- R2: A word presented with `wr_valid` high appears on `wr_out_data` one clock later, with `wr_out_valid` high, equal to the word XOR the replicated flip bit of its block.
- R3: At a block start the flip bit takes the value of the random bit XOR the current phase. It then stays fixed for every word until the next block start, whatever the random input does in between.
- R4: Counting block starts from reset, with index n starting at 0, the phase of block n is bit M of n. With the default M = 4, blocks 0 to 15 have phase 0 and blocks 16 to 31 have phase 1.
- R5: At a block start the new flip bit is stored in the flag of the slot on `blk_slot`. A read with `rd_valid` high returns, one clock later, `rd_data` XOR the replicated flag of slot `rd_slot`, with `rd_out_valid` high.
- R6: Feeding a written word back through the read stage for the same slot returns the original word, both for flip 0 and for flip 1.
- R7: A word presented in the same cycle as a block start is encoded with that new block's flip bit.
- R8: In a cycle with `wr_valid` low, `wr_out_valid` falls one clock later and `wr_out_data` holds its previous value.
- R9: Take any 2^(M+1) consecutive blocks whose random bits repeat with period 2^M. Exactly 2^M of those blocks are inverted, whatever the share of ones in the random pattern.
- R10: A slot's flag is unchanged by block starts that target other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rnd_in | input | 1 | Random bit. Used directly in port mode; mixed into the LFSR feedback in LFSR mode |
| blk_start | input | 1 | Marks the first cycle of a new weight block |
| blk_slot | input | SLOT_W | Slot whose flag receives the new block's flip bit |
| wr_valid | input | 1 | Write word valid |
| wr_data | input | WIDTH | Plain weight word to encode |
| wr_out_valid | output | 1 | Encoded word valid, toward the SRAM |
| wr_out_data | output | WIDTH | Encoded word, toward the SRAM |
| rd_valid | input | 1 | Read word valid, from the SRAM |
| rd_slot | input | SLOT_W | Slot the read word belongs to |
| rd_data | input | WIDTH | Encoded word read from the SRAM |
| rd_out_valid | output | 1 | Decoded word valid |
| rd_out_data | output | WIDTH | Decoded word, toward compute |

## Verification
A wrong phase or block count shows only at block starts. With a constant random input, every output word in the block after the bad wrap is inverted where it should be plain, or plain where it should be inverted, visible one clock after that block starts. A corrupted or misaddressed slot flag stays hidden until that slot is read. It then shows as a fully inverted decoded word one clock after the read. For this reason the bench reads every slot back after a series of writes. A flip bit that changes in the middle of a block shows on the very next word of that block.

// File: rtl/wflip_pkg.sv
`timescale 1ns/1ps
package wflip_pkg;
   typedef enum logic {
      SRC_PORT = 1'b0,
      SRC_LFSR = 1'b1
   } rnd_src_e;

   localparam int LFSR_W = 16;
endpackage

// File: rtl/wflip_decider.sv
`timescale 1ns/1ps
module wflip_decider
   import wflip_pkg::*;
#(
   parameter int              CNT_W = 4,
   parameter rnd_src_e        SRC   = SRC_PORT,
   parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rnd_in,
   input  logic blk_start,
   output logic flag_next,
   output logic flag_q
);
   logic             rnd_bit;
   logic [CNT_W-1:0] blk_cnt;
   logic             phase;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("wflip_decider: CNT_W must be at least 1");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("wflip_decider: SEED must be nonzero");
   end

   if (SRC == SRC_LFSR) begin : g_lfsr
      logic [LFSR_W-1:0] lfsr;
      logic              fb;
      assign fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
      always_ff @(posedge clk) begin
         if (!rst_n) lfsr <= SEED;
         else        lfsr <= {lfsr[LFSR_W-2:0], fb ^ rnd_in};
      end
      assign rnd_bit = lfsr[LFSR_W-1];
   end else begin : g_port
      assign rnd_bit = rnd_in;
   end

   assign flag_next = rnd_bit ^ phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_cnt <= '0;
         phase   <= 1'b0;
         flag_q  <= 1'b0;
      end else if (blk_start) begin
         flag_q  <= flag_next;
         blk_cnt <= blk_cnt + 1'b1;
         if (&blk_cnt) phase <= ~phase;
      end
   end

   // R3: flip bit only moves at a block start
   p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_start |=> $stable(flag_q));
   // R4: phase only moves when the counter wraps
   p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_start || !(&blk_cnt)) |=> $stable(phase));
endmodule

// File: rtl/wflip_xor_stage.sv
`timescale 1ns/1ps
module wflip_xor_stage #(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   input  logic             flip,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data
);
   logic [WIDTH-1:0] mixed;

   if (WIDTH < 1) begin : g_bad_width
      $error("wflip_xor_stage: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign mixed[i] = in_data[i] ^ flip;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= mixed;
      end
   end

   // R2: a valid word produces a valid output one clock later
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8: idle cycle drops valid and holds data
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)));
endmodule

// File: rtl/wflip_flag_file.sv
`timescale 1ns/1ps
module wflip_flag_file #(
   parameter int  SLOTS  = 8,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic              wr_bit,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic              rd_bit
);
   logic [SLOTS-1:0] flags;

   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("wflip_flag_file: SLOTS must be a power of two, at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     flags <= '0;
      else if (wr_en) flags[wr_slot] <= wr_bit;
   end

   assign rd_bit = flags[rd_slot];

   // R10: no write, no change to any slot
   p_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(flags));
   // R5: a written flag is found in its slot afterwards
   p_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (flags[$past(wr_slot)] == $past(wr_bit)));
endmodule

// File: rtl/wflip_codec.sv
`timescale 1ns/1ps
module wflip_codec
   import wflip_pkg::*;
#(
   parameter int                WIDTH  = 64,
   parameter int                SLOTS  = 8,
   parameter int                CNT_W  = 4,
   parameter rnd_src_e          SRC    = SRC_PORT,
   parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
   localparam int               SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rnd_in,
   input  logic              blk_start,
   input  logic [SLOT_W-1:0] blk_slot,
   input  logic              wr_valid,
   input  logic [WIDTH-1:0]  wr_data,
   output logic              wr_out_valid,
   output logic [WIDTH-1:0]  wr_out_data,
   input  logic              rd_valid,
   input  logic [SLOT_W-1:0] rd_slot,
   input  logic [WIDTH-1:0]  rd_data,
   output logic              rd_out_valid,
   output logic [WIDTH-1:0]  rd_out_data
);
   logic flag_next, flag_q, wr_flip, rd_flip;

   wflip_decider #(.CNT_W(CNT_W), .SRC(SRC), .SEED(SEED)) u_decider (
      .clk(clk), .rst_n(rst_n), .rnd_in(rnd_in), .blk_start(blk_start),
      .flag_next(flag_next), .flag_q(flag_q)
   );

   // a word arriving with the block start belongs to the new block
   assign wr_flip = blk_start ? flag_next : flag_q;

   wflip_xor_stage #(.WIDTH(WIDTH)) u_enc (
      .clk(clk), .rst_n(rst_n), .in_valid(wr_valid), .in_data(wr_data),
      .flip(wr_flip), .out_valid(wr_out_valid), .out_data(wr_out_data)
   );

   wflip_flag_file #(.SLOTS(SLOTS)) u_flags (
      .clk(clk), .rst_n(rst_n), .wr_en(blk_start), .wr_slot(blk_slot),
      .wr_bit(flag_next), .rd_slot(rd_slot), .rd_bit(rd_flip)
   );

   wflip_xor_stage #(.WIDTH(WIDTH)) u_dec (
      .clk(clk), .rst_n(rst_n), .in_valid(rd_valid), .in_data(rd_data),
      .flip(rd_flip), .out_valid(rd_out_valid), .out_data(rd_out_data)
   );

   // R7: word in a block-start cycle carries the flag stored for that block
   p_start_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && wr_valid) |=> (wr_out_data == ($past(wr_data) ^ {WIDTH{flag_q}})));
endmodule

// File: tb/wflip_codec_test.sv
`timescale 1ns/1ps
module wflip_codec_test;
   localparam int W  = 64;
   localparam int SW = 3;
   localparam int M  = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic rnd_in, blk_start, wr_valid, rd_valid;
   logic [SW-1:0] blk_slot, rd_slot;
   logic [W-1:0]  wr_data, rd_data;
   logic wr_out_valid, rd_out_valid;
   logic [W-1:0] wr_out_data, rd_out_data;

   int checks = 0;
   int failures = 0;
   int bcount = 0;
   logic [7:0] meta = '0;
   bit done = 0;

   wflip_codec uut (
      .clk(clk), .rst_n(rst_n), .rnd_in(rnd_in), .blk_start(blk_start),
      .blk_slot(blk_slot), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_out_valid(wr_out_valid), .wr_out_data(wr_out_data),
      .rd_valid(rd_valid), .rd_slot(rd_slot), .rd_data(rd_data),
      .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data)
   );

   always #10 clk = ~clk;

   // {rnd, slot, word}
   localparam logic [67:0] VEC [8] = '{
      {1'b0, 3'd0, 64'h0123_4567_89AB_CDEF},
      {1'b1, 3'd1, 64'hFFFF_0000_FFFF_0000},
      {1'b1, 3'd2, 64'h0000_0000_0000_0000},
      {1'b0, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF},
      {1'b1, 3'd4, 64'hDEAD_BEEF_CAFE_F00D},
      {1'b0, 3'd5, 64'h8000_0000_0000_0001},
      {1'b1, 3'd6, 64'h5555_AAAA_3333_CCCC},
      {1'b0, 3'd7, 64'h7F7F_0101_FE80_1234}
   };

   localparam logic [15:0] BIAS_PAT = 16'b1101_1011_0111_0110;

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic exp_flip(input logic r, input int n);
      return r ^ n[M];
   endfunction

   // start one block with a word; returns expected flip
   task automatic start_block(input logic r, input logic [SW-1:0] s,
                              input logic [W-1:0] d, output logic e);
      e = exp_flip(r, bcount);
      bcount++;
      meta[s] = e;
      rnd_in = r; blk_slot = s; blk_start = 1'b1;
      wr_valid = 1'b1; wr_data = d;
      tick();
      blk_start = 1'b0; wr_valid = 1'b0;
   endtask

   initial begin
      #4000000;
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic e;
      logic [W-1:0] held;
      int ones;
      rst_n = 1'b0; rnd_in = 1'b0; blk_start = 1'b0; blk_slot = '0;
      wr_valid = 1'b0; wr_data = '0; rd_valid = 1'b0; rd_slot = '0; rd_data = '0;
      @(negedge clk); tick(); tick();
      rst_n = 1'b1;

      // R1: reset state
      chk(!wr_out_valid && !rd_out_valid, "R1 valids", {62'd0, wr_out_valid, rd_out_valid}, '0);
      chk(wr_out_data == '0, "R1 write data", wr_out_data, '0);
      rd_valid = 1'b1; rd_slot = 3'd5; rd_data = 64'hA5A5_0F0F_1234_5678;
      tick(); rd_valid = 1'b0;
      chk(rd_out_data == 64'hA5A5_0F0F_1234_5678, "R1 flag zero", rd_out_data, 64'hA5A5_0F0F_1234_5678);

      // table walk: R2 R5 R6 R7
      for (int i = 0; i < 8; i++) begin
         logic [W-1:0] d;
         d = VEC[i][63:0];
         start_block(VEC[i][67], VEC[i][66:64], d, e);
         chk(wr_out_valid, "R2 valid", {63'd0, wr_out_valid}, 64'd1);
         chk(wr_out_data == (d ^ {W{e}}), "R7 start word", wr_out_data, d ^ {W{e}});
         rd_valid = 1'b1; rd_slot = VEC[i][66:64]; rd_data = wr_out_data;
         tick(); rd_valid = 1'b0;
         chk(rd_out_valid, "R5 read valid", {63'd0, rd_out_valid}, 64'd1);
         chk(rd_out_data == d, "R6 round trip", rd_out_data, d);
      end

      // R3: later word in same block, random input changed
      rnd_in = ~VEC[7][67];
      wr_valid = 1'b1; wr_data = 64'h1111_2222_3333_4444;
      tick(); wr_valid = 1'b0;
      chk(wr_out_data == (64'h1111_2222_3333_4444 ^ {W{meta[7]}}), "R3 held flip",
          wr_out_data, 64'h1111_2222_3333_4444 ^ {W{meta[7]}});

      // R8: idle cycle
      held = wr_out_data;
      wr_data = 64'hFEED_FACE_0000_9999;
      tick();
      chk(!wr_out_valid, "R8 valid low", {63'd0, wr_out_valid}, '0);
      chk(wr_out_data == held, "R8 hold", wr_out_data, held);

      // R10 R5: every slot flag by reading zero words
      for (int s = 0; s < 8; s++) begin
         rd_valid = 1'b1; rd_slot = s[SW-1:0]; rd_data = '0;
         tick(); rd_valid = 1'b0;
         chk(rd_out_data == {W{meta[s]}}, "R10 slot kept", rd_out_data, {W{meta[s]}});
      end

      // R4: constant zero random bit across the phase change
      for (int k = 0; k < 20; k++) begin
         logic [W-1:0] exp;
         exp = {W{1'b0 ^ bcount[M]}};
         start_block(1'b0, 3'd2, '0, e);
         chk(wr_out_data == exp, "R4 phase", wr_out_data, exp);
      end

      // R9: biased pattern over two periods
      ones = 0;
      for (int k = 0; k < 32; k++) begin
         start_block(BIAS_PAT[k % 16], 3'd3, '0, e);
         if (wr_out_data[0]) ones++;
      end
      chk(ones == 16, "R9 balance", 64'(ones), 64'd16);

      // R6 with the last slot written after R9
      rd_valid = 1'b1; rd_slot = 3'd3; rd_data = {W{meta[3]}} ^ 64'h0F0F_F0F0_1357_9BDF;
      tick(); rd_valid = 1'b0;
      chk(rd_out_data == 64'h0F0F_F0F0_1357_9BDF, "R6 decode", rd_out_data, 64'h0F0F_F0F0_1357_9BDF);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule